// File: doc/BRIEF.md
# ADC Self-Test Step Sequencer

This block schedules built-in self-test conversions on the dedicated test channel of a successive-approximation ADC. Three test algorithms exist: a supply check of three steps, a resistive-DAC check of nineteen steps and a capacitive-DAC check of seventeen steps. For every step the sequencer presents the algorithm and step index to the analog front end, runs a sample phase whose length comes from a per-algorithm 8-bit field, then a fixed conversion phase, and then captures the 12-bit result and raises an end-of-conversion flag.

Software uses it in one of two ways. In single-step mode it picks an algorithm and a step and raises start; exactly one conversion follows. In scan mode it holds start high and the block walks every step of supply, resistive and capacitive in that order, again and again, finishing the pass in progress once start drops. Because the supply steps must not be split, a normal-conversion request that arrives while a supply step is running is parked and released only after the supply group is over.

Top module: `adc_bist_seq`

## Requirements
- R1: After reset busy, sampleOn, stepDone, eoc and normGo are 0, and resData, curAlg and curStep are 0.
- R2: Algorithm codes on algSel and curAlg are 0 = supply, 1 = resistive, 2 = capacitive; the valid step indices are 0..2, 0..18 and 0..16 respectively, and curStep never leaves that range while busy.
- R3: In single-step mode (scanMode = 0), a rising edge of start while stEnable is 1 runs exactly the selected step once; resData then holds the afeData value present in the last conversion cycle, and busy returns to 0 even if start stays high.
- R4: A step spends the algorithm's programmed sample count in the sample phase (a count of 0 behaves as 1), then CONV_CYCLES cycles converting; eoc rises on the clock edge N + CONV_CYCLES after the edge that launches the step.
- R5: In scan mode the steps run with no idle cycle between them in the order supply 0..2, resistive 0..18, capacitive 0..16, each step using its own algorithm's sample count, and the algorithm only ever advances supply to resistive to capacitive to supply.
- R6: In scan mode a new pass begins at supply step 0 directly after capacitive step 16 while start is still 1; with start at 0 the current pass completes and the block goes idle.
- R7: eoc is set when a step completes and cleared by eocClr = 1; when both happen in the same cycle the set wins.
- R8: With stEnable at 0 no step launches, and clearing stEnable during a step returns the block to idle on the next edge without setting eoc.
- R9: A single-step launch with algorithm code 3 or a step index beyond the algorithm's last step is ignored: busy and eoc stay 0.
- R10: A one-cycle normReq pulse produces one one-cycle normGo pulse; normGo is never 1 while a supply step runs, so a request made during the supply group is granted in the cycle right after supply step 2 completes, and outside it in the cycle after the request.
- R11: stepDone is a one-cycle pulse per completed step, eoc is already 1 in that cycle, and resData changes only in a cycle where stepDone is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stEnable | input | 1 | Test channel enable |
| scanMode | input | 1 | 1 = scan all algorithms, 0 = single step |
| start | input | 1 | Start level (rising edge in single-step mode) |
| algSel | input | 2 | Algorithm for single-step mode |
| stepSel | input | 5 | Step index for single-step mode |
| sampSup | input | 8 | Sample-phase count for supply steps |
| sampRes | input | 8 | Sample-phase count for resistive steps |
| sampCap | input | 8 | Sample-phase count for capacitive steps |
| eocClr | input | 1 | Write-one clear of eoc |
| normReq | input | 1 | Normal-conversion request pulse |
| afeData | input | 12 | Conversion result from the analog front end |
| busy | output | 1 | A step is in progress |
| sampleOn | output | 1 | Sample phase active |
| curAlg | output | 2 | Algorithm presented to the front end |
| curStep | output | 5 | Step presented to the front end |
| stepDone | output | 1 | One-cycle pulse at step completion |
| eoc | output | 1 | Sticky end-of-conversion flag |
| resData | output | 12 | Captured result of the last step |
| normGo | output | 1 | Release pulse for a normal conversion |

## Verification
The bound checker watches, on every cycle, that the step index stays inside its algorithm's range, that the algorithm only advances in scan order, that normGo is never granted during a supply step, that a dropped enable stops the block, and that eoc and resData only move together with stepDone. What the checker cannot show is the exact cycle counts of each sample and conversion phase, the full 39-step order, the repeat and stop behaviour of scan mode and the treatment of illegal selections; the bench measures these directly with a vector table of single steps, a complete scan pass with a parked normal request, and directed enable, zero-count and flag-priority cases.

// File: rtl/adc_bist_pkg.sv
package adc_bist_pkg;

  typedef enum logic [1:0] {
    ALG_SUP = 2'd0,
    ALG_RES = 2'd1,
    ALG_CAP = 2'd2
  } algT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;     // load first step of a run
    logic scanFirst;  // launch begins at supply step 0
    logic advance;    // move to next step of a scan
    logic sampTick;   // count the sample phase down
    logic convLoad;   // load the conversion counter
    logic convTick;   // count the conversion phase down
    logic finish;     // step complete: capture and flag
  } ctlStrobeT;

endpackage

// File: rtl/adc_bist_ctrl.sv
module adc_bist_ctrl
  import adc_bist_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stEnable,
  input  logic      scanMode,
  input  logic      start,
  input  logic      startRise,
  input  logic      selValid,
  input  logic      sampLast,
  input  logic      convLast,
  input  logic      seqLast,
  output ctlStrobeT ctl,
  output logic      busy,
  output logic      sampleOn
);

  stateT state, stateNxt;
  logic  runScan;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (stEnable && (scanMode ? start : (startRise && selValid))) begin
          ctl.launch    = 1'b1;
          ctl.scanFirst = scanMode;
          stateNxt      = ST_SAMP;
        end
      end
      ST_SAMP: begin
        if (!stEnable) begin
          stateNxt = ST_IDLE;
        end else if (sampLast) begin
          ctl.convLoad = 1'b1;
          stateNxt     = ST_CONV;
        end else begin
          ctl.sampTick = 1'b1;
        end
      end
      ST_CONV: begin
        if (!stEnable) begin
          stateNxt = ST_IDLE;
        end else if (convLast) begin
          ctl.finish = 1'b1;
          if (runScan && !seqLast) begin
            ctl.advance = 1'b1;
            stateNxt    = ST_SAMP;
          end else if (runScan && start) begin
            ctl.launch    = 1'b1;
            ctl.scanFirst = 1'b1;
            stateNxt      = ST_SAMP;
          end else begin
            stateNxt = ST_IDLE;
          end
        end else begin
          ctl.convTick = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      runScan <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.launch) runScan <= ctl.scanFirst;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign sampleOn = (state == ST_SAMP);

endmodule

// File: rtl/adc_bist_dp.sv
module adc_bist_dp
  import adc_bist_pkg::*;
#(
  parameter int SAMP_W      = 8,
  parameter int DATA_W      = 12,
  parameter int STEP_W      = 5,
  parameter int CONV_CYCLES = 4,
  parameter int S_STEPS     = 3,
  parameter int R_STEPS     = 19,
  parameter int C_STEPS     = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic              busy,
  input  logic              start,
  input  logic [1:0]        algSel,
  input  logic [STEP_W-1:0] stepSel,
  input  logic [SAMP_W-1:0] sampSup,
  input  logic [SAMP_W-1:0] sampRes,
  input  logic [SAMP_W-1:0] sampCap,
  input  logic              eocClr,
  input  logic              normReq,
  input  logic [DATA_W-1:0] afeData,
  output logic              startRise,
  output logic              selValid,
  output logic              sampLast,
  output logic              convLast,
  output logic              seqLast,
  output logic [1:0]        curAlg,
  output logic [STEP_W-1:0] curStep,
  output logic              stepDone,
  output logic              eoc,
  output logic [DATA_W-1:0] resData,
  output logic              normGo
);

  localparam int CONV_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  logic              startQ;
  logic              pend;
  logic [SAMP_W-1:0] sampCnt;
  logic [CONV_W-1:0] convCnt;
  logic [1:0]        nAlg;
  logic [STEP_W-1:0] nStep;
  logic              inSupply;

  function automatic logic [STEP_W-1:0] lastOf(input logic [1:0] a);
    case (a)
      ALG_SUP: lastOf = STEP_W'(S_STEPS - 1);
      ALG_RES: lastOf = STEP_W'(R_STEPS - 1);
      default: lastOf = STEP_W'(C_STEPS - 1);
    endcase
  endfunction

  function automatic logic [SAMP_W-1:0] sampOf(input logic [1:0] a);
    case (a)
      ALG_SUP: sampOf = sampSup;
      ALG_RES: sampOf = sampRes;
      default: sampOf = sampCap;
    endcase
  endfunction

  assign startRise = start && !startQ;
  assign selValid  = (algSel != 2'd3) && (stepSel <= lastOf(algSel));
  assign sampLast  = (sampCnt <= SAMP_W'(1));
  assign convLast  = (convCnt == '0);
  assign seqLast   = (curAlg == ALG_CAP) && (curStep == lastOf(ALG_CAP));
  assign inSupply  = busy && (curAlg == ALG_SUP);
  assign normGo    = pend && !inSupply;

  // next algorithm and step for a launch or a scan advance
  always_comb begin
    if (ctl.launch) begin
      nAlg  = ctl.scanFirst ? ALG_SUP : algSel;
      nStep = ctl.scanFirst ? '0 : stepSel;
    end else if (curStep == lastOf(curAlg)) begin
      nAlg  = curAlg + 2'd1;
      nStep = '0;
    end else begin
      nAlg  = curAlg;
      nStep = curStep + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ   <= 1'b0;
      curAlg   <= ALG_SUP;
      curStep  <= '0;
      sampCnt  <= '0;
      convCnt  <= '0;
      stepDone <= 1'b0;
      eoc      <= 1'b0;
      resData  <= '0;
      pend     <= 1'b0;
    end else begin
      startQ <= start;
      if (ctl.launch || ctl.advance) begin
        curAlg  <= nAlg;
        curStep <= nStep;
        sampCnt <= sampOf(nAlg);
      end else if (ctl.sampTick) begin
        sampCnt <= sampCnt - SAMP_W'(1);
      end
      if (ctl.convLoad) begin
        convCnt <= CONV_W'(CONV_CYCLES - 1);
      end else if (ctl.convTick) begin
        convCnt <= convCnt - CONV_W'(1);
      end
      stepDone <= ctl.finish;
      if (ctl.finish) begin
        eoc     <= 1'b1;
        resData <= afeData;
      end else if (eocClr) begin
        eoc <= 1'b0;
      end
      pend <= normReq || (pend && !normGo);
    end
  end

endmodule

// File: rtl/adc_bist_seq.sv
module adc_bist_seq
  import adc_bist_pkg::*;
#(
  parameter int SAMP_W      = 8,
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 4,
  parameter int S_STEPS     = 3,
  parameter int R_STEPS     = 19,
  parameter int C_STEPS     = 17,
  localparam int MAX_STEPS  = (S_STEPS > R_STEPS) ?
                              ((S_STEPS > C_STEPS) ? S_STEPS : C_STEPS) :
                              ((R_STEPS > C_STEPS) ? R_STEPS : C_STEPS),
  localparam int STEP_W     = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stEnable,
  input  logic              scanMode,
  input  logic              start,
  input  logic [1:0]        algSel,
  input  logic [STEP_W-1:0] stepSel,
  input  logic [SAMP_W-1:0] sampSup,
  input  logic [SAMP_W-1:0] sampRes,
  input  logic [SAMP_W-1:0] sampCap,
  input  logic              eocClr,
  input  logic              normReq,
  input  logic [DATA_W-1:0] afeData,
  output logic              busy,
  output logic              sampleOn,
  output logic [1:0]        curAlg,
  output logic [STEP_W-1:0] curStep,
  output logic              stepDone,
  output logic              eoc,
  output logic [DATA_W-1:0] resData,
  output logic              normGo
);

  ctlStrobeT ctl;
  logic      startRise, selValid, sampLast, convLast, seqLast;

  adc_bist_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stEnable(stEnable), .scanMode(scanMode),
    .start(start), .startRise(startRise), .selValid(selValid),
    .sampLast(sampLast), .convLast(convLast), .seqLast(seqLast),
    .ctl(ctl), .busy(busy), .sampleOn(sampleOn)
  );

  adc_bist_dp #(
    .SAMP_W(SAMP_W), .DATA_W(DATA_W), .STEP_W(STEP_W),
    .CONV_CYCLES(CONV_CYCLES), .S_STEPS(S_STEPS),
    .R_STEPS(R_STEPS), .C_STEPS(C_STEPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .start(start),
    .algSel(algSel), .stepSel(stepSel), .sampSup(sampSup),
    .sampRes(sampRes), .sampCap(sampCap), .eocClr(eocClr),
    .normReq(normReq), .afeData(afeData), .startRise(startRise),
    .selValid(selValid), .sampLast(sampLast), .convLast(convLast),
    .seqLast(seqLast), .curAlg(curAlg), .curStep(curStep),
    .stepDone(stepDone), .eoc(eoc), .resData(resData), .normGo(normGo)
  );

endmodule

// File: rtl/adc_bist_chk.sv
module adc_bist_chk #(
  parameter int DATA_W  = 12,
  parameter int STEP_W  = 5,
  parameter int S_STEPS = 3,
  parameter int R_STEPS = 19,
  parameter int C_STEPS = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              stEnable,
  input logic              busy,
  input logic [1:0]        curAlg,
  input logic [STEP_W-1:0] curStep,
  input logic              stepDone,
  input logic              eoc,
  input logic [DATA_W-1:0] resData,
  input logic              normGo
);

  function automatic logic [STEP_W-1:0] limOf(input logic [1:0] a);
    case (a)
      2'd0:    limOf = STEP_W'(S_STEPS - 1);
      2'd1:    limOf = STEP_W'(R_STEPS - 1);
      default: limOf = STEP_W'(C_STEPS - 1);
    endcase
  endfunction

  // R8
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stEnable |=> !busy);

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (curAlg != 2'd3) && (curStep <= limOf(curAlg)));

  // R11
  done_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |-> eoc);

  // R7
  eoc_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eoc) |-> stepDone);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resData) |-> stepDone);

  // R10
  atomic_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    normGo |-> !(busy && curAlg == 2'd0));

  // R5
  alg_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && curAlg != $past(curAlg)) |->
      ((curAlg == $past(curAlg) + 2'd1) || (curAlg == 2'd0 && $past(curAlg) == 2'd2)));

endmodule

bind adc_bist_seq adc_bist_chk #(
  .DATA_W(DATA_W), .STEP_W(STEP_W), .S_STEPS(S_STEPS),
  .R_STEPS(R_STEPS), .C_STEPS(C_STEPS)
) u_chk (
  .clk(clk), .rstN(rstN), .stEnable(stEnable), .busy(busy),
  .curAlg(curAlg), .curStep(curStep), .stepDone(stepDone), .eoc(eoc),
  .resData(resData), .normGo(normGo)
);

// File: tb/adc_bist_seq_bench.sv
`timescale 1ns/1ps
module adc_bist_seq_bench;

  localparam int CONV = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       stEnable, scanMode, start, eocClr, normReq;
  logic [1:0] algSel;
  logic [4:0] stepSel;
  logic [7:0] sampSup, sampRes, sampCap;
  logic [11:0] afeData;
  logic       busy, sampleOn, stepDone, eoc, normGo;
  logic [1:0] curAlg;
  logic [4:0] curStep;
  logic [11:0] resData;

  int chkCnt  = 0;
  int failCnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // front-end model: result encodes which step was converted
  assign afeData = {curAlg, 5'd0, curStep};

  adc_bist_seq #(.CONV_CYCLES(CONV)) u_adc_bist_seq (
    .clk(clk), .rstN(rstN), .stEnable(stEnable), .scanMode(scanMode),
    .start(start), .algSel(algSel), .stepSel(stepSel), .sampSup(sampSup),
    .sampRes(sampRes), .sampCap(sampCap), .eocClr(eocClr), .normReq(normReq),
    .afeData(afeData), .busy(busy), .sampleOn(sampleOn), .curAlg(curAlg),
    .curStep(curStep), .stepDone(stepDone), .eoc(eoc), .resData(resData),
    .normGo(normGo)
  );

  // single-step vectors: {alg[1:0], step[4:0], valid}
  localparam logic [7:0] VEC [9] = '{
    {2'd0, 5'd0,  1'b1}, {2'd0, 5'd2,  1'b1}, {2'd0, 5'd3,  1'b0},
    {2'd1, 5'd0,  1'b1}, {2'd1, 5'd18, 1'b1}, {2'd1, 5'd19, 1'b0},
    {2'd2, 5'd16, 1'b1}, {2'd2, 5'd17, 1'b0}, {2'd3, 5'd0,  1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic int sampEff(input logic [1:0] a);
    int n;
    n = (a == 2'd0) ? int'(sampSup) : (a == 2'd1) ? int'(sampRes) : int'(sampCap);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [11:0] codeOf(input logic [1:0] a, input logic [4:0] s);
    return {a, 5'd0, s};
  endfunction

  task automatic runOne(input logic [1:0] a, input logic [4:0] s, input bit valid);
    int n;
    bit seen, sawBusy;
    eocClr = 1'b1; tick; eocClr = 1'b0;
    check(eoc == 1'b0, "R7 clear", eoc, 0);
    algSel = a; stepSel = s; start = 1'b1;
    if (valid) begin
      n = 0; seen = 0;
      for (int i = 0; i < 600 && !seen; i++) begin
        tick; n++;
        if (eoc) seen = 1;
      end
      check(n == sampEff(a) + CONV + 1, "R4 latency", n, sampEff(a) + CONV + 1);
      check(resData == codeOf(a, s), "R3 result", resData, codeOf(a, s));
      repeat (3) tick;
      check(!busy, "R3 single step", busy, 0);
    end else begin
      sawBusy = 0;
      for (int i = 0; i < 20; i++) begin
        tick;
        if (busy) sawBusy = 1;
      end
      check(!sawBusy && !eoc, "R9 ignored", {sawBusy, eoc}, 0);
    end
    start = 1'b0; tick;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int idx, gap, goCnt, goIdx, dn, expGap;
    bit goDone, sawBusy;
    logic [1:0] ea;
    logic [4:0] es;
    rstN = 1'b0; stEnable = 1'b1; scanMode = 1'b0; start = 1'b0;
    eocClr = 1'b0; normReq = 1'b0; algSel = 2'd0; stepSel = 5'd0;
    sampSup = 8'd5; sampRes = 8'd3; sampCap = 8'd2;
    repeat (3) tick;
    rstN = 1'b1;
    tick;
    // R1 reset state
    check(!busy && !sampleOn && !stepDone && !eoc && !normGo, "R1 flags",
          {busy, sampleOn, stepDone, eoc, normGo}, 0);
    check(resData == 0 && curAlg == 0 && curStep == 0, "R1 values", resData, 0);

    // vector table: single-step mode, R2 R3 R4 R9
    for (int v = 0; v < 9; v++) runOne(VEC[v][7:6], VEC[v][5:1], VEC[v][0]);

    // R4 zero sample count behaves as one
    sampCap = 8'd0;
    runOne(2'd2, 5'd5, 1'b1);
    sampCap = 8'd2;

    // R7 set wins over a simultaneous clear
    eocClr = 1'b1; algSel = 2'd0; stepSel = 5'd1; start = 1'b1;
    for (int i = 0; i < 100 && !stepDone; i++) tick;
    check(eoc == 1'b1, "R7 set wins", eoc, 1);
    tick;
    check(eoc == 1'b0, "R7 clear held", eoc, 0);
    eocClr = 1'b0; start = 1'b0; tick;

    // R8 no launch while disabled
    stEnable = 1'b0; algSel = 2'd1; stepSel = 5'd0; start = 1'b1;
    sawBusy = 0;
    for (int i = 0; i < 10; i++) begin tick; if (busy) sawBusy = 1; end
    check(!sawBusy, "R8 disabled launch", sawBusy, 0);
    start = 1'b0; stEnable = 1'b1; eocClr = 1'b1; tick; eocClr = 1'b0;
    // R8 abort mid-step
    start = 1'b1; repeat (3) tick;
    check(busy, "R8 running", busy, 1);
    stEnable = 1'b0; tick;
    check(!busy, "R8 abort", busy, 0);
    repeat (20) tick;
    check(!eoc, "R8 no flag", eoc, 0);
    start = 1'b0; stEnable = 1'b1; tick;

    // scan pass: R5 order and gaps, R10 parked request
    scanMode = 1'b1; start = 1'b1;
    idx = 0; gap = 0; goCnt = 0; goIdx = -1; goDone = 0;
    for (int i = 0; i < 3000 && idx < 40; i++) begin
      tick; gap++;
      if (normGo) begin goCnt++; goIdx = idx; goDone = stepDone; end
      if (stepDone) begin
        if (idx < 3)       begin ea = 2'd0; es = 5'(idx);      end
        else if (idx < 22) begin ea = 2'd1; es = 5'(idx - 3);  end
        else if (idx < 39) begin ea = 2'd2; es = 5'(idx - 22); end
        else               begin ea = 2'd0; es = 5'd0;         end
        expGap = sampEff(ea) + CONV + ((idx == 0) ? 1 : 0);
        if (idx < 39) begin
          check(resData == codeOf(ea, es), "R5 order", resData, codeOf(ea, es));
          check(gap == expGap, "R5 gap", gap, expGap);
        end else begin
          check(resData == codeOf(2'd0, 5'd0), "R6 restart", resData, 0);
          check(gap == expGap && busy, "R6 restart gap", gap, expGap);
        end
        gap = 0; idx++;
      end
      normReq = (idx == 0 && gap == 1);
    end
    check(goCnt == 1 && goIdx == 2 && goDone, "R10 parked grant", goIdx, 2);

    // R6 drop start: the pass completes then idles
    start = 1'b0; dn = 0;
    for (int i = 0; i < 3000; i++) begin
      tick;
      if (stepDone) dn++;
      if (!busy) break;
    end
    check(dn == 38, "R6 pass completes", dn, 38);
    repeat (5) tick;
    check(!busy, "R6 idle", busy, 0);

    // R10 grant outside the supply group
    normReq = 1'b1; tick; normReq = 1'b0;
    check(normGo, "R10 idle grant", normGo, 1);
    tick;
    check(!normGo, "R10 pulse width", normGo, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

endmodule